// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This peripheral holds two independent 16-bit up-counters. Each counter advances on a count tick taken from a shared free-running prescaler. The divisor is picked per channel by a 2-bit clock-select code and equals 8 shifted left by twice the code, so the choices are 8, 32, 128 and 512 input clocks. When a tick finds the counter equal to its compare value, the counter restarts from zero. If the channel's interrupt enable is set, the channel also emits a one-cycle interrupt pulse.

Software reaches the timer through a 16-bit synchronous register port that uses byte offsets and 16-bit accesses only. Offset 0 is a shared start register. Offsets 2, 4 and 6 hold the control, counter and compare registers of channel 0, and offsets 8, 10 and 12 hold the same three registers for channel 1.

Each channel is a two-state machine. In `CH_HALT` the counter holds its value. In `CH_COUNT` the counter advances on the ticks of the selected divisor. Writing the channel's start bit as 1 takes the START transition from `CH_HALT` to `CH_COUNT`. Writing it as 0 takes the STOP transition back to `CH_HALT`. Any other write leaves the state as it is.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset:
  - both counters read 0x0000;
  - both compare registers read 0xFFFF;
  - both control registers read 0x0080;
  - the start register reads 0x0000;
  - both interrupt outputs are low.
- R2: The register map uses byte offsets:
  - offset 0 is the start register;
  - offsets 2, 4 and 6 are the control, counter and compare registers of channel 0;
  - offsets 8, 10 and 12 are the control, counter and compare registers of channel 1;
  - offset 14 and every odd offset are unmapped: reads return 0xFFFF and writes change nothing.
  
  Read data appears on `rd_data` in the cycle after the read request and holds until the next read.
- R3: In the control register:
  - bits [1:0] are the clock select and bit 6 is the interrupt enable;
  - bit 7 always reads 1;
  - every other bit reads 0, whatever is written.
- R4: Start register bit n set to 1 runs channel n, and set to 0 stops it. Reading the start register returns the run state of each channel in bits [1:0] and 0 in the other bits. Bits above 1 are ignored on write.
- R5: A running channel with clock select k advances once every 8<<(2k) input clocks. Over a run window of N cycles, where N is a multiple of that divisor, the counter advances exactly N/(8<<(2k)) times.
- R6: A stopped channel holds its counter value. A restart continues counting from the held value.
- R7: A count tick that finds the counter equal to the compare value sets the counter to 0. This includes a compare value of 0xFFFF.
- R8: A tick on a match raises the channel's interrupt output for exactly one cycle when the interrupt enable is 1. When the interrupt enable is 0, the output stays low.
- R9: A counter write loads the written value directly, even while the channel runs. A counter write takes precedence over a tick in the same cycle.
- R10: The channels are independent. Running, loading or matching one channel leaves the other channel's counter and interrupt unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 2 | One-cycle match pulse per channel |

## Verification
The assertions assume three things about the inputs:
- every access lasts exactly one cycle, with `bus_we` and `bus_addr` stable during it;
- the clock selects stay within their four legal codes;
- reset is held for at least one clock edge.

The stimulus drives each access for one clock on the falling edge and then drops `bus_sel`. It writes control values only through the register port, where the field is 2 bits wide by construction. The run windows are framed by start and stop writes a known number of edges apart, so the expected counter values follow from the divisor alone, whatever phase the prescaler is in.

// File: rtl/tmr2_pkg.sv
package tmr2_pkg;

    // Channel run state
    typedef enum logic [0:0] {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;

    localparam int unsigned CKS_W     = 2;            // clock select width
    localparam int unsigned NUM_TAPS  = 1 << CKS_W;   // selectable divisors
    localparam int unsigned BASE_LOG  = 3;            // smallest divisor = 8
    localparam int unsigned STEP_LOG  = 2;            // each code multiplies by 4
    localparam int unsigned IE_BIT    = 6;            // interrupt enable position
    localparam int unsigned ONE_BIT   = 7;            // always-one position
    localparam int unsigned REGS_PER_CH = 3;          // control, counter, compare

endpackage

// File: rtl/tmr2_prescaler.sv
module tmr2_prescaler
    import tmr2_pkg::*;
#(
    parameter int unsigned TAPS = NUM_TAPS,
    parameter int unsigned BLOG = BASE_LOG,
    parameter int unsigned SLOG = STEP_LOG
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tap
);
    localparam int unsigned PRE_W = BLOG + SLOG * (TAPS - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Each tap is high for the last cycle of its power-of-two period
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam int unsigned L = BLOG + SLOG * k;
        assign tap[k] = &pre_q[L-1:0];
    end

    AST_TAP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tap[0] |=> !tap[0]);  // R5

    AST_SLOW_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        tap[TAPS-1] |-> tap[0]);  // R5

endmodule

// File: rtl/tmr2_channel.sv
module tmr2_channel
    import tmr2_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CS_W  = CKS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [(1<<CS_W)-1:0] tap,
    input  logic                 run_we,
    input  logic                 run_bit,
    input  logic                 ctl_we,
    input  logic                 cnt_we,
    input  logic                 cmp_we,
    input  logic [CNT_W-1:0]     wdata,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [CNT_W-1:0]     cmp_o,
    output logic [CS_W-1:0]      cks_o,
    output logic                 ie_o,
    output logic                 running_o,
    output logic                 irq_o
);
    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q;
    logic [CS_W-1:0]  cks_q;
    logic             ie_q, irq_q, irq_d;
    logic             tick, match;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // Next state: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT:  if (run_we && run_bit)  state_d = CH_COUNT;
            CH_COUNT: if (run_we && !run_bit) state_d = CH_HALT;
        endcase
    end

    // Outputs of the state: tick, counter next value, match pulse
    always_comb begin
        tick  = (state_q == CH_COUNT) && tap[cks_q];
        match = (cnt_q == cmp_q);
        cnt_d = cnt_q;
        irq_d = 1'b0;
        if (cnt_we) begin
            cnt_d = wdata;
        end else if (tick) begin
            if (match) begin
                cnt_d = '0;
                irq_d = ie_q;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '1;
            cks_q <= '0;
            ie_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
            if (cmp_we) cmp_q <= wdata;
            if (ctl_we) begin
                cks_q <= wdata[CS_W-1:0];
                ie_q  <= wdata[IE_BIT];
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign cmp_o     = cmp_q;
    assign cks_o     = cks_q;
    assign ie_o      = ie_q;
    assign running_o = (state_q == CH_COUNT);
    assign irq_o     = irq_q;

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !cnt_we) |=> $stable(cnt_q));  // R6

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tap[cks_q] && !cnt_we) |=> $stable(cnt_q));  // R5

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tap[cks_q] && cnt_q == cmp_q && !cnt_we) |=> (cnt_q == '0));  // R7

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);  // R8

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ie_q));  // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wdata)));  // R9

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr2_pkg::*;
#(
    parameter int unsigned NCH    = 2,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    irq
);
    localparam int unsigned IDX_W = ADDR_W - 1;

    logic [NUM_TAPS-1:0] tap;
    logic [IDX_W-1:0]    idx;
    logic                aligned, wr, rd;
    logic [DATA_W-1:0]   rd_next, rd_q;

    logic [DATA_W-1:0] cnt_a [NCH];
    logic [DATA_W-1:0] cmp_a [NCH];
    logic [CKS_W-1:0]  cks_a [NCH];
    logic [NCH-1:0]    ie_a, run_a;

    assign idx     = bus_addr[ADDR_W-1:1];
    assign aligned = !bus_addr[0];
    assign wr      = bus_sel && bus_we && aligned;
    assign rd      = bus_sel && !bus_we;

    tmr2_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (tap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned BASE = 1 + REGS_PER_CH * c;
        tmr2_channel #(.CNT_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tap       (tap),
            .run_we    (wr && idx == '0),
            .run_bit   (bus_wdata[c]),
            .ctl_we    (wr && idx == IDX_W'(BASE)),
            .cnt_we    (wr && idx == IDX_W'(BASE + 1)),
            .cmp_we    (wr && idx == IDX_W'(BASE + 2)),
            .wdata     (bus_wdata),
            .cnt_o     (cnt_a[c]),
            .cmp_o     (cmp_a[c]),
            .cks_o     (cks_a[c]),
            .ie_o      (ie_a[c]),
            .running_o (run_a[c]),
            .irq_o     (irq[c])
        );
    end

    // Read decode
    always_comb begin
        rd_next = '1;
        if (aligned) begin
            if (idx == '0) begin
                rd_next = '0;
                rd_next[NCH-1:0] = run_a;
            end
            for (int c = 0; c < NCH; c++) begin
                if (idx == IDX_W'(1 + REGS_PER_CH * c)) begin
                    rd_next = '0;
                    rd_next[CKS_W-1:0] = cks_a[c];
                    rd_next[IE_BIT]    = ie_a[c];
                    rd_next[ONE_BIT]   = 1'b1;
                end
                if (idx == IDX_W'(2 + REGS_PER_CH * c)) rd_next = cnt_a[c];
                if (idx == IDX_W'(3 + REGS_PER_CH * c)) rd_next = cmp_a[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_q <= '0;
        else if (rd) rd_q <= rd_next;
    end

    assign rd_data = rd_q;

    AST_CTL_BIT7_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'(2)) |=> rd_data[ONE_BIT]);  // R3

    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[0]) |=> (rd_data == '1));  // R2

    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rd_data));  // R2

endmodule

// File: tb/dual_cmp_timer_test.sv
`timescale 1ns/1ps
module dual_cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    int rise [2];
    int high [2];
    logic [1:0] irq_prev = '0;
    bit done = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    dual_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .irq(irq)
    );

    // Pulse monitor, sampled away from the active edge
    initial begin
        rise[0] = 0; rise[1] = 0; high[0] = 0; high[1] = 0;
    end
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (irq[c]) high[c]++;
                if (irq[c] && !irq_prev[c]) rise[c]++;
            end
            irq_prev <= irq;
        end
    end

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data;
    endtask

    // Run the channels in mask for exactly n clock edges
    task automatic run_for(logic [1:0] mask, int n);
        wr(4'd0, {14'd0, mask});
        repeat (n - 2) @(negedge clk);
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'd0, v);  chk("R1 start", v, 16'h0000);
        rd(4'd2, v);  chk("R1 ctl0", v, 16'h0080);
        rd(4'd4, v);  chk("R1 cnt0", v, 16'h0000);
        rd(4'd6, v);  chk("R1 cmp0", v, 16'hFFFF);
        rd(4'd8, v);  chk("R1 ctl1", v, 16'h0080);
        rd(4'd10, v); chk("R1 cnt1", v, 16'h0000);
        rd(4'd12, v); chk("R1 cmp1", v, 16'hFFFF);
        chk("R1 irq", {14'd0, irq}, 16'h0000);
    endtask

    task automatic t_map;
        logic [15:0] v;
        rd(4'd14, v); chk("R2 unmapped 14", v, 16'hFFFF);
        rd(4'd3, v);  chk("R2 odd offset", v, 16'hFFFF);
        wr(4'd14, 16'h0000);
        wr(4'd7, 16'h0000);
        rd(4'd6, v);  chk("R2 odd write ignored", v, 16'hFFFF);
        rd(4'd12, v); chk("R2 cmp1 untouched", v, 16'hFFFF);
        rd(4'd4, v);  chk("R2 cnt0 untouched", v, 16'h0000);
    endtask

    task automatic t_ctl;
        logic [15:0] v;
        wr(4'd2, 16'hFFFF); rd(4'd2, v); chk("R3 all ones", v, 16'h00C3);
        wr(4'd2, 16'h0000); rd(4'd2, v); chk("R3 zero", v, 16'h0080);
        wr(4'd8, 16'h0042); rd(4'd8, v); chk("R3 ch1", v, 16'h00C2);
        wr(4'd8, 16'h0000);
    endtask

    task automatic t_start;
        logic [15:0] v;
        wr(4'd0, 16'h0001); rd(4'd0, v); chk("R4 ch0 run", v, 16'h0001);
        wr(4'd0, 16'h0003); rd(4'd0, v); chk("R4 both run", v, 16'h0003);
        wr(4'd0, 16'hFFFC); rd(4'd0, v); chk("R4 upper ignored", v, 16'h0000);
    endtask

    task automatic t_rate(logic [1:0] cks, int n);
        logic [15:0] v;
        int d = 8 << (2 * cks);
        wr(4'd2, {14'd0, cks});
        wr(4'd6, 16'hFFFF);
        wr(4'd4, 16'h0000);
        run_for(2'b01, n);
        rd(4'd4, v);
        chk("R5 rate", v, 16'(n / d));
    endtask

    task automatic t_hold;
        logic [15:0] v;
        wr(4'd2, 16'h0000);
        wr(4'd4, 16'h1234);
        repeat (600) @(negedge clk);
        rd(4'd4, v); chk("R6 stopped hold", v, 16'h1234);
        run_for(2'b01, 800);
        rd(4'd4, v); chk("R6 restart continues", v, 16'h1234 + 16'd100);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        int r0, h0;
        wr(4'd6, 16'd4);
        wr(4'd2, 16'h0040);
        wr(4'd4, 16'h0000);
        r0 = rise[0]; h0 = high[0];
        run_for(2'b01, 40);
        repeat (4) @(negedge clk);
        rd(4'd4, v); chk("R7 wrap to zero", v, 16'h0000);
        chk("R8 one pulse", 16'(rise[0] - r0), 16'd1);
        chk("R8 pulse width", 16'(high[0] - h0), 16'd1);
        run_for(2'b01, 80);
        repeat (4) @(negedge clk);
        rd(4'd4, v); chk("R7 two wraps", v, 16'h0000);
        chk("R8 two pulses", 16'(rise[0] - r0), 16'd3);
        chk("R10 no ch1 pulse", 16'(rise[1]), 16'd0);
    endtask

    task automatic t_noirq;
        logic [15:0] v;
        int r0;
        wr(4'd2, 16'h0000);
        wr(4'd6, 16'd4);
        wr(4'd4, 16'h0000);
        r0 = rise[0];
        run_for(2'b01, 40);
        repeat (4) @(negedge clk);
        rd(4'd4, v); chk("R7 wrap without ie", v, 16'h0000);
        chk("R8 no pulse when disabled", 16'(rise[0] - r0), 16'd0);
        run_for(2'b01, 16);
        rd(4'd4, v); chk("R5 partial period", v, 16'd2);
    endtask

    task automatic t_top;
        logic [15:0] v;
        wr(4'd2, 16'h0000);
        wr(4'd6, 16'hFFFF);
        wr(4'd4, 16'hFFFE);
        run_for(2'b01, 24);
        rd(4'd4, v); chk("R7 wrap at FFFF", v, 16'h0001);
    endtask

    task automatic t_load_running;
        logic [15:0] v;
        wr(4'd2, 16'h0003);
        wr(4'd6, 16'hFFFF);
        wr(4'd4, 16'h0000);
        wr(4'd0, 16'h0001);
        repeat (20) @(negedge clk);
        wr(4'd4, 16'h0010);
        wr(4'd0, 16'h0000);
        rd(4'd4, v);
        n_chk++;
        if (v !== 16'h0010 && v !== 16'h0011) begin
            n_bad++;
            $display("FAIL R9 load while running: got %h expected 0010 or 0011", v);
        end
    endtask

    task automatic t_indep;
        logic [15:0] v;
        int r0, r1;
        wr(4'd2, 16'h0000);
        wr(4'd4, 16'h0055);
        wr(4'd8, 16'h0000);
        wr(4'd12, 16'hFFFF);
        wr(4'd10, 16'h0000);
        run_for(2'b10, 800);
        rd(4'd10, v); chk("R10 ch1 counts", v, 16'd100);
        rd(4'd4, v);  chk("R10 ch0 untouched", v, 16'h0055);
        wr(4'd12, 16'd1);
        wr(4'd8, 16'h0040);
        wr(4'd10, 16'h0000);
        r0 = rise[0]; r1 = rise[1];
        run_for(2'b10, 16);
        repeat (4) @(negedge clk);
        rd(4'd10, v); chk("R7 ch1 wrap", v, 16'h0000);
        chk("R8 ch1 pulse", 16'(rise[1] - r1), 16'd1);
        chk("R10 ch0 quiet", 16'(rise[0] - r0), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_ctl;
        t_start;
        t_rate(2'd0, 800);
        t_rate(2'd1, 3200);
        t_rate(2'd2, 1280);
        t_rate(2'd3, 5120);
        t_hold;
        t_wrap;
        t_noirq;
        t_top;
        t_load_running;
        t_indep;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule